// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one bus cycle at a time on a shared, time-multiplexed address/data bus on the processor side. The bus has 16 data lines and a 20-bit address. The upper four address lines are carried on a separate group of pins. The core places a request on the request port and holds it until the one-cycle done pulse. The request carries the address, the direction, a high-byte enable, the write data and a two-bit segment code. The sequencer then steps through an address phase, a command phase, a transfer phase, any number of wait phases and a closing phase. It drives the address-latch strobe, the read and write strobes, the bus output enable and the transceiver direction.

An external address latch captures the address on the falling edge of the latch strobe. During the data phases the high pins carry the segment code instead of address bits, so the rest of the system can see which segment formed the address. The memory or I/O device slows a cycle down by holding the ready input low. Between cycles, and whenever no request is pending, the sequencer sits in idle cycles with the bus released.

Top module: `bus_cycle_seq`

## Requirements
- R1: After a synchronous reset the sequencer is idle: `ale`=0, `rd_n`=1, `wr_n`=1, `bhe_n`=1, `bus_oe`=0, `done`=0, `bus_out`=0, `bus_hi`=0, `dir_tx`=1 and `rdata`=0.
- R2: While idle and `req_valid` is low, the outputs stay at the R1 values and no cycle starts.
- R3: In the first clock after an idle clock with `req_valid` high (the address phase), the block drives `ale`=1, `bus_oe`=1 and `dir_tx`=1, with `bus_out`=address[15:0] and `bus_hi`=address[19:16]. It also drives `bhe_n` as the inverse of `req_hi_en`, and both strobes are inactive.
- R4: In every phase after the address phase up to and including the closing phase, `bus_hi[1:0]` carries the latched segment code and `bus_hi[3:2]` is 0. The codes are 00 extra, 01 stack, 10 code or none, 11 data.
- R5: A read (`req_write`=0) holds `rd_n`=0, `bus_oe`=0 and `dir_tx`=0 from the command phase through the closing phase.
- R6: A write (`req_write`=1) holds `wr_n`=0, `bus_oe`=1, `dir_tx`=1 and `bus_out`=write data from the command phase through the closing phase.
- R7: `ready` is sampled at the end of the transfer phase and at the end of each wait phase. When it is low, the block inserts a wait phase and all outputs are held. When it is high, the closing phase follows. `ready` has no effect in the command phase.
- R8: `done` is high for exactly one clock, in the closing phase. For a read, `rdata` equals `bus_in` as sampled on the edge that ends the last transfer or wait phase. `rdata` keeps that value until the next read.
- R9: The closing phase is always followed by at least one idle clock. The request fields are taken only on the edge that leaves idle, so changing them during a cycle has no effect on it.
- R10: A cycle with N wait phases takes 4+N clocks from the accepting edge up to and including the clock where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request pending; held until done |
| req_addr | input | 20 | Byte address of the cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hi_en | input | 1 | High byte lane enabled |
| req_wdata | input | 16 | Write data |
| req_seg | input | 2 | Segment code shown during data phases |
| ready | input | 1 | Device ready, active high |
| bus_in | input | 16 | Data read from the shared bus |
| bus_out | output | 16 | Value driven on the shared bus |
| bus_oe | output | 1 | Output enable for the shared bus |
| bus_hi | output | 4 | High address lines / status |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bhe_n | output | 1 | High byte enable, active low |
| dir_tx | output | 1 | Transceiver direction, 1 = toward bus |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read data |

## Verification
The hardest situation to reach from the ports is a long stretch of wait phases whose ending edge must capture exactly the right `bus_in` value. Around it, `ready` also drops in the command phase, where it must be ignored, and the request fields change in the middle of the cycle. The bench makes the device model hold `ready` low for a chosen number of transfer and wait phases and pulls it low during the command phase. It sets `bus_in` to a fresh value every clock and scrambles the request fields once the address phase has passed. A behavioural model compares every output on every clock, so a capture one edge early or late shows up as a wrong `rdata`.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } bus_phase_e;

    typedef struct packed {
        bus_phase_e phase;
    } seq_state_t;

endpackage

// File: rtl/bcs_seq.sv
module bcs_seq
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       ready,
    output bus_phase_e phase_q
);

    seq_state_t st_d;
    seq_state_t st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_T1;
                end
            end
            PH_T1: st_d.phase = PH_T2;
            PH_T2: st_d.phase = PH_T3;
            PH_T3, PH_TW: begin
                if (ready) begin
                    st_d.phase = PH_T4;
                end else begin
                    st_d.phase = PH_TW;
                end
            end
            PH_T4: st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_q = st_q.phase;

endmodule

// File: rtl/bcs_hold.sv
module bcs_hold
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_phase_e        phase,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_hi_en,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic              ready,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic              write_q,
    output logic              hi_en_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [SEG_W-1:0]  seg_q,
    output logic [DATA_W-1:0] rdata_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              hi_en;
        logic [DATA_W-1:0] wdata;
        logic [SEG_W-1:0]  seg;
        logic [DATA_W-1:0] rdata;
    } hold_t;

    hold_t h_d;
    hold_t h_q;
    logic  take;
    logic  grab;

    always_comb begin
        take = (phase == PH_IDLE) && req_valid;
        grab = ((phase == PH_T3) || (phase == PH_TW)) && ready && !h_q.write;
        h_d  = h_q;
        if (take) begin
            h_d.addr  = req_addr;
            h_d.write = req_write;
            h_d.hi_en = req_hi_en;
            h_d.wdata = req_wdata;
            h_d.seg   = req_seg;
        end
        if (grab) begin
            h_d.rdata = bus_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign addr_q  = h_q.addr;
    assign write_q = h_q.write;
    assign hi_en_q = h_q.hi_en;
    assign wdata_q = h_q.wdata;
    assign seg_q   = h_q.seg;
    assign rdata_q = h_q.rdata;

endmodule

// File: rtl/bcs_drive.sv
module bcs_drive
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  bus_phase_e               phase,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     write,
    input  logic                     hi_en,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [SEG_W-1:0]         seg,
    output logic [DATA_W-1:0]        bus_out,
    output logic                     bus_oe,
    output logic [ADDR_W-DATA_W-1:0] bus_hi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     bhe_n,
    output logic                     dir_tx,
    output logic                     done
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic data_phase;

    always_comb begin
        data_phase = (phase == PH_T2) || (phase == PH_T3) ||
                     (phase == PH_TW) || (phase == PH_T4);
        bus_out = '0;
        bus_oe  = 1'b0;
        bus_hi  = '0;
        ale     = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        bhe_n   = 1'b1;
        dir_tx  = 1'b1;
        done    = 1'b0;
        if (phase == PH_T1) begin
            ale     = 1'b1;
            bus_oe  = 1'b1;
            bus_out = addr[DATA_W-1:0];
            bus_hi  = addr[ADDR_W-1:DATA_W];
            bhe_n   = !hi_en;
        end else if (data_phase) begin
            bus_hi[SEG_W-1:0] = seg;
            bhe_n = !hi_en;
            if (write) begin
                wr_n    = 1'b0;
                bus_oe  = 1'b1;
                bus_out = wdata;
            end else begin
                rd_n   = 1'b0;
                dir_tx = 1'b0;
            end
            done = (phase == PH_T4);
        end
    end

    if (HI_W < SEG_W) begin : g_bad_width
        initial $error("bcs_drive: high lines narrower than segment code");
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_write,
    input  logic                     req_hi_en,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [SEG_W-1:0]         req_seg,
    input  logic                     ready,
    input  logic [DATA_W-1:0]        bus_in,
    output logic [DATA_W-1:0]        bus_out,
    output logic                     bus_oe,
    output logic [ADDR_W-DATA_W-1:0] bus_hi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     bhe_n,
    output logic                     dir_tx,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata
);

    bus_phase_e        phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic              hi_en_q;
    logic [DATA_W-1:0] wdata_q;
    logic [SEG_W-1:0]  seg_q;

    bcs_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .ready     (ready),
        .phase_q   (phase_q)
    );

    bcs_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) i_hold (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase_q),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_hi_en (req_hi_en),
        .req_wdata (req_wdata),
        .req_seg   (req_seg),
        .ready     (ready),
        .bus_in    (bus_in),
        .addr_q    (addr_q),
        .write_q   (write_q),
        .hi_en_q   (hi_en_q),
        .wdata_q   (wdata_q),
        .seg_q     (seg_q),
        .rdata_q   (rdata)
    );

    bcs_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) i_drive (
        .phase   (phase_q),
        .addr    (addr_q),
        .write   (write_q),
        .hi_en   (hi_en_q),
        .wdata   (wdata_q),
        .seg     (seg_q),
        .bus_out (bus_out),
        .bus_oe  (bus_oe),
        .bus_hi  (bus_hi),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .bhe_n   (bhe_n),
        .dir_tx  (dir_tx),
        .done    (done)
    );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
    import bcs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input bus_phase_e phase,
    input logic       ready,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       bus_oe,
    input logic       dir_tx,
    input logic       done
);

    // R3: the address phase is followed by exactly one active strobe
    p_strobe_after_ale_r3: assert property (@(posedge clk) disable iff (rst)
        ale |=> (rd_n != wr_n));

    // R5: read and write strobes are never active together
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R6: the bus is only driven while the transceiver points outward
    p_oe_dir_r6: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> dir_tx);

    // R7: ready low at the end of a transfer or wait phase holds the cycle
    p_wait_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (((phase == PH_T3) || (phase == PH_TW)) && !ready)
        |=> ((phase == PH_TW) && !done && $stable(rd_n) && $stable(wr_n)));

    // R7: ready high ends the wait and leads to completion
    p_ready_finish_r7: assert property (@(posedge clk) disable iff (rst)
        (((phase == PH_T3) || (phase == PH_TW)) && ready) |=> done);

    // R8: done lasts one clock
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: completion is always followed by an idle clock
    p_idle_after_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> ((phase == PH_IDLE) && !ale && rd_n && wr_n));

endmodule

bind bus_cycle_seq bcs_checker i_bcs_checker (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase_q),
    .ready  (ready),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .bus_oe (bus_oe),
    .dir_tx (dir_tx),
    .done   (done)
);

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [19:0] req_addr;
    logic        req_write;
    logic        req_hi_en;
    logic [15:0] req_wdata;
    logic [1:0]  req_seg;
    logic        ready;
    logic [15:0] bus_in;
    logic [15:0] bus_out;
    logic        bus_oe;
    logic [3:0]  bus_hi;
    logic        ale, rd_n, wr_n, bhe_n, dir_tx, done;
    logic [15:0] rdata;

    always #2 clk = ~clk;

    bus_cycle_seq i_bus_cycle_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_hi_en(req_hi_en), .req_wdata(req_wdata),
        .req_seg(req_seg), .ready(ready), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .bus_hi(bus_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .bhe_n(bhe_n), .dir_tx(dir_tx), .done(done), .rdata(rdata)
    );

    int vecs = 0;
    int errs = 0;
    int wait_left = 0;
    logic t2_ready = 1'b1;

    // reference model: 0 idle, 1 address, 2 command, 3 transfer, 4 wait, 5 closing
    int          m_ph = 0;
    logic        m_live = 1'b0;
    logic [19:0] m_addr;
    logic        m_wr, m_hien;
    logic [15:0] m_wdata, m_rdata;
    logic [1:0]  m_seg;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_rdata = '0; m_live = 1'b1;
            m_addr = '0; m_wr = 0; m_hien = 0; m_wdata = '0; m_seg = '0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                       m_addr = req_addr; m_wr = req_write; m_hien = req_hi_en;
                       m_wdata = req_wdata; m_seg = req_seg; m_ph = 1;
                   end
                1: m_ph = 2;
                2: m_ph = 3;
                3, 4: if (ready) begin
                          if (!m_wr) m_rdata = bus_in;
                          m_ph = 5;
                      end else m_ph = 4;
                default: m_ph = 0;
            endcase
        end
    end

    // compare every clock
    always @(negedge clk) begin
        if (m_live) begin
            string t;
            logic e_ale, e_rd, e_wr, e_oe, e_dir, e_bhe, e_done;
            logic [3:0] e_hi;
            logic [15:0] e_out;
            case (m_ph)
                0: t = "R2";
                1: t = "R3";
                4: t = "R7";
                default: t = m_wr ? "R6" : "R5";
            endcase
            e_ale = (m_ph == 1);
            e_rd = !(m_ph >= 2 && !m_wr);
            e_wr = !(m_ph >= 2 && m_wr);
            e_oe = (m_ph == 1) || (m_ph >= 2 && m_wr);
            e_dir = !(m_ph >= 2 && !m_wr);
            e_bhe = (m_ph == 0) ? 1'b1 : !m_hien;
            e_done = (m_ph == 5);
            e_hi = (m_ph == 0) ? 4'h0 : (m_ph == 1) ? m_addr[19:16] : {2'b00, m_seg};
            e_out = (m_ph == 1) ? m_addr[15:0] : (m_ph >= 2 && m_wr) ? m_wdata : 16'h0;
            chk(t, "ale", ale, e_ale);
            chk(t, "rd_n", rd_n, e_rd);
            chk(t, "wr_n", wr_n, e_wr);
            chk(t, "bus_oe", bus_oe, e_oe);
            chk(t, "dir_tx", dir_tx, e_dir);
            chk(t, "bhe_n", bhe_n, e_bhe);
            chk((m_ph >= 2) ? "R4" : t, "bus_hi", bus_hi, e_hi);
            if (e_oe || m_ph == 0) chk(t, "bus_out", bus_out, e_out);
            chk("R8", "done", done, e_done);
            chk("R8", "rdata", rdata, m_rdata);
        end
    end

    // device side: ready and read data
    always @(negedge clk) begin
        #1;
        bus_in = 16'($urandom);
        if (m_ph == 3 || m_ph == 4) begin
            if (wait_left > 0) begin
                ready = 1'b0;
                wait_left--;
            end else ready = 1'b1;
        end else if (m_ph == 2) ready = t2_ready;
        else ready = 1'b1;
    end

    task automatic run_cycle(input logic [19:0] a, input logic w, input logic he,
                             input logic [15:0] wd, input logic [1:0] sg,
                             input int nwait, input logic t2r, input logic scramble,
                             input logic keep_req, output int lat);
        @(negedge clk); #1;
        req_addr = a; req_write = w; req_hi_en = he; req_wdata = wd; req_seg = sg;
        req_valid = 1'b1; wait_left = nwait; t2_ready = t2r; lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (scramble && lat == 1) begin
                #1;
                req_addr = ~a; req_write = ~w; req_wdata = ~wd; req_seg = ~sg; req_hi_en = ~he;
            end
        end while (!done && lat < 64);
        if (scramble) begin
            chk("R9", "bus_out at close", bus_out, w ? wd : 16'h0);
            chk("R9", "bus_hi at close", bus_hi, {2'b00, sg});
        end
        #1;
        if (!keep_req) req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lat;
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        req_hi_en = 1'b0; req_wdata = '0; req_seg = '0; ready = 1'b1; bus_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "ale", ale, 1'b0);
        chk("R1", "rd_n/wr_n", {rd_n, wr_n}, 2'b11);
        chk("R1", "bus_oe", bus_oe, 1'b0);
        chk("R1", "done", done, 1'b0);
        chk("R1", "rdata", rdata, 16'h0);
        #1 rst = 1'b0;
        // R2: idle without a request
        repeat (5) @(negedge clk);
        chk("R2", "ale idle", ale, 1'b0);

        // R10: no-wait write and read
        run_cycle(20'hABCDE, 1'b1, 1'b1, 16'h1234, 2'b00, 0, 1'b1, 1'b0, 1'b0, lat);
        chk("R10", "write latency", lat, 4);
        run_cycle(20'h54321, 1'b0, 1'b0, 16'h0, 2'b01, 0, 1'b1, 1'b0, 1'b0, lat);
        chk("R10", "read latency", lat, 4);
        // R7: waits, ready low in command phase ignored
        run_cycle(20'hFFFFF, 1'b0, 1'b1, 16'h0, 2'b10, 3, 1'b0, 1'b0, 1'b0, lat);
        chk("R7", "read with 3 waits latency", lat, 7);
        run_cycle(20'h00000, 1'b1, 1'b0, 16'hBEEF, 2'b11, 2, 1'b0, 1'b0, 1'b0, lat);
        chk("R7", "write with 2 waits latency", lat, 6);
        run_cycle(20'h12345, 1'b0, 1'b1, 16'h0, 2'b11, 0, 1'b0, 1'b0, 1'b0, lat);
        chk("R7", "command-phase ready ignored", lat, 4);
        // R9: fields scrambled mid-cycle
        run_cycle(20'h0F0F0, 1'b1, 1'b1, 16'hC3C3, 2'b01, 1, 1'b1, 1'b1, 1'b0, lat);
        run_cycle(20'hF0F0F, 1'b0, 1'b0, 16'h0, 2'b10, 2, 1'b1, 1'b1, 1'b0, lat);
        // R9: request kept high through close -> idle clock, then new cycle
        run_cycle(20'h11111, 1'b1, 1'b0, 16'h5A5A, 2'b00, 0, 1'b1, 1'b0, 1'b1, lat);
        @(negedge clk);
        chk("R9", "idle after close ale", ale, 1'b0);
        chk("R9", "idle after close done", done, 1'b0);
        @(negedge clk);
        chk("R9", "next cycle ale", ale, 1'b1);
        #1 req_valid = 1'b0;
        repeat (8) @(negedge clk);
        // R8: read data held across a write
        for (int i = 0; i < 6; i++) begin
            run_cycle(20'(i * 20'h2B3C1), i[0], i[1], 16'(i * 16'h1111), 2'(i), i % 3,
                      i[0], 1'b0, 1'b0, lat);
            chk("R10", "latency loop", lat, 4 + i % 3);
        end
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule